// File: doc/BRIEF.md
# Streaming Approximate Pattern Matcher

This block watches a byte stream, one byte per clock, and raises a flag whenever the bytes seen so far end in a stretch that lies within K edits of a fixed pattern of M positions. Four edits are allowed, each costing one: replacing a byte, inserting an extra byte, dropping a pattern byte, and swapping two neighbouring bytes. Each pattern position accepts either of two byte values, so case variants or look-alike characters can share one position. The pattern, M and K are fixed at elaboration.

The matcher is a bit-parallel nondeterministic automaton held in one-hot form. Every (pattern position, error level) pair with a non-trivial value has its own flip-flop, and so does every (position, level) pair of a pending neighbour swap. All of them advance together on each accepted byte. Pairs that are always reachable are tied high and take no flip-flop: position 0 at every level, and any position not above its level. Typical use is deep payload inspection, where a rule must still fire on deliberately altered content.

Top module: `approx_match`

## Requirements
- R1: A synchronous active-high `rst` drives `match_o` low at the next edge and clears all byte history, so bytes accepted before the reset never contribute to a later match.
- R2: Each byte accepted with `in_valid` high at a rising edge is reflected in `match_o` from that same edge onwards. A match is never reported before the byte that completes it.
- R3: Pattern position p (1 = first byte of the pattern, M = last) is taken from bits [8*(M-p)+7 : 8*(M-p)] of both `PAT_A` and `PAT_B`, so a string literal reads in pattern order. A byte fits position p when it equals either of those two bytes.
- R4: An exact occurrence of the pattern ending at the latest accepted byte raises `match_o`, at any offset in the stream.
- R5: A byte that replaces one pattern byte costs one edit.
- R6: An extra byte inserted into the occurrence costs one edit.
- R7: A pattern byte missing from the occurrence costs one edit, including at the first or last position.
- R8: Two neighbouring pattern bytes that appear in swapped order cost one edit in total, not two.
- R9: After each accepted byte, `match_o` is high exactly when some run of accepted bytes ending at that byte has an optimal-alignment edit distance (the edits of R5 to R8, with no byte edited twice) of at most K to the pattern. This requires 1 <= K < M. A run that needs K+1 edits leaves `match_o` low.
- R10: While `in_valid` is low, `in_byte` is ignored and both `match_o` and the matcher state hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Accept `in_byte` at this edge |
| in_byte | input | 8 | Stream byte |
| match_o | output | 1 | Registered flag: recent input within K edits of the pattern |

## Verification
On every cycle the assertions check four things: the reset and hold behaviour, that the flag agrees with the final-column state flops, that the reachable-state sets nest from each error level to the next for both grid and swap flops, and that an exact final byte after a complete prefix raises the flag. Whether the flag is right for a given byte sequence depends on the whole edit-distance rule. Only the bench scenarios can show that. The bench compares every accepted byte against a dynamic-programming distance model and also runs targeted strings for each edit type, for the swap-versus-two-edits boundary, and for hold and mid-stream reset.

// File: rtl/approx_match_pkg.sv
package approx_match_pkg;

  typedef logic [7:0] sym_t;

  // 8-input AND over bitwise equality: one comparator per pattern byte
  function automatic logic sym_eq(input sym_t a, input sym_t b);
    return &(a ~^ b);
  endfunction

endpackage

// File: rtl/am_symbol_cmp.sv
module am_symbol_cmp
  import approx_match_pkg::*;
#(
  parameter int              M     = 3,
  parameter logic [8*M-1:0]  PAT_A = "ABC",
  parameter logic [8*M-1:0]  PAT_B = "AbC"
) (
  input  sym_t       sym,
  output logic [M:1] hit
);

  for (genvar p = 1; p <= M; p++) begin : g_pos
    localparam sym_t ALT0 = PAT_A[8*(M-p) +: 8];
    localparam sym_t ALT1 = PAT_B[8*(M-p) +: 8];
    // two alternatives per position: OR of two comparators
    assign hit[p] = sym_eq(sym, ALT0) | sym_eq(sym, ALT1);
  end

endmodule

// File: rtl/am_xpose_bank.sv
module am_xpose_bank #(
  parameter int M = 3,
  parameter int K = 2
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    adv,
  input  logic [K-1:0][M-2:0]     src,
  input  logic [M:2]              ahead,
  output logic [K-1:0][M-2:0]     xq
);

  // xq[j][i]: column i reached at level j one byte ago, and that byte
  // equalled pattern position i+2 (first half of a swapped pair)
  always_ff @(posedge clk) begin
    if (rst) begin
      xq <= '0;
    end else if (adv) begin
      for (int j = 0; j < K; j++) begin
        for (int i = 0; i <= M - 2; i++) begin
          xq[j][i] <= src[j][i] & ahead[i+2];
        end
      end
    end
  end

endmodule

// File: rtl/am_edit_grid.sv
module am_edit_grid #(
  parameter int M = 3,
  parameter int K = 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 adv,
  input  logic [M:1]           hit,
  input  logic [K-1:0][M-2:0]  xq,
  output logic [K:0][M:0]      st,
  output logic                 fin_nxt
);

  logic [K:0] last_d;

  // column 0 is reachable at every level: free start at any offset
  for (genvar j = 0; j <= K; j++) begin : g_origin
    assign st[j][0] = 1'b1;
  end

  for (genvar i = 1; i <= M; i++) begin : g_col
    for (genvar j = 0; j <= K; j++) begin : g_lvl
      if (j >= i) begin : g_const
        // i pattern bytes can always be dropped within j >= i edits
        assign st[j][i] = 1'b1;
      end else begin : g_ff
        logic d;
        logic q;
        // step terms of cell (i-s, j-s); s > 0 folds trailing drops
        always_comb begin
          d = 1'b0;
          for (int s = 0; s <= j; s++) begin
            d = d | (st[j-s][i-s-1] & hit[i-s]);
            if (j - s > 0) begin
              d = d | st[j-s-1][i-s]
                    | (st[j-s-1][i-s-1] & ~hit[i-s]);
              if (i - s >= 2) begin
                d = d | (xq[j-s-1][i-s-2] & hit[i-s-1]);
              end
            end
          end
        end
        always_ff @(posedge clk) begin
          if (rst)      q <= 1'b0;
          else if (adv) q <= d;
        end
        assign st[j][i] = q;
        if (i == M) begin : g_tail
          assign last_d[j] = d;
        end
      end
    end
  end

  assign fin_nxt = |last_d;

endmodule

// File: rtl/approx_match.sv
module approx_match
  import approx_match_pkg::*;
#(
  parameter int              M     = 3,
  parameter int              K     = 2,
  parameter logic [8*M-1:0]  PAT_A = "ABC",
  parameter logic [8*M-1:0]  PAT_B = "AbC"
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       in_valid,
  input  logic [7:0] in_byte,
  output logic       match_o
);

  logic [M:1]          hit;
  logic [K:0][M:0]     grid_st;
  logic [K-1:0][M-2:0] xsrc;
  logic [K-1:0][M-2:0] xpose_st;
  logic                fin_nxt;
  logic                match_q;

  am_symbol_cmp #(.M(M), .PAT_A(PAT_A), .PAT_B(PAT_B)) u_cmp (
    .sym (in_byte),
    .hit (hit)
  );

  for (genvar j = 0; j < K; j++) begin : g_xs_lvl
    for (genvar i = 0; i <= M - 2; i++) begin : g_xs_col
      assign xsrc[j][i] = grid_st[j][i];
    end
  end

  am_xpose_bank #(.M(M), .K(K)) u_xpose (
    .clk   (clk),
    .rst   (rst),
    .adv   (in_valid),
    .src   (xsrc),
    .ahead (hit[M:2]),
    .xq    (xpose_st)
  );

  am_edit_grid #(.M(M), .K(K)) u_grid (
    .clk     (clk),
    .rst     (rst),
    .adv     (in_valid),
    .hit     (hit),
    .xq      (xpose_st),
    .st      (grid_st),
    .fin_nxt (fin_nxt)
  );

  always_ff @(posedge clk) begin
    if (rst)           match_q <= 1'b0;
    else if (in_valid) match_q <= fin_nxt;
  end

  assign match_o = match_q;

endmodule

// File: rtl/approx_match_chk.sv
module approx_match_chk
  import approx_match_pkg::*;
#(
  parameter int              M     = 3,
  parameter int              K     = 2,
  parameter logic [8*M-1:0]  PAT_A = "ABC",
  parameter logic [8*M-1:0]  PAT_B = "AbC"
) (
  input logic                clk,
  input logic                rst,
  input logic                in_valid,
  input logic [7:0]          in_byte,
  input logic                match_o,
  input logic [K:0][M:0]     st,
  input logic [K-1:0][M-2:0] xs
);

  logic col_any;
  logic nest_ok;
  logic last_hit;

  always_comb begin
    col_any = 1'b0;
    for (int j = 0; j <= K; j++) col_any = col_any | st[j][M];
  end

  always_comb begin
    nest_ok = 1'b1;
    for (int j = 0; j < K; j++) begin
      nest_ok = nest_ok & (&(~st[j] | st[j+1]));
    end
    for (int j = 0; j < K - 1; j++) begin
      nest_ok = nest_ok & (&(~xs[j] | xs[j+1]));
    end
  end

  assign last_hit = sym_eq(in_byte, PAT_A[7:0]) | sym_eq(in_byte, PAT_B[7:0]);

  // R1
  reset_clear_chk: assert property (@(posedge clk) rst |=> !match_o);

  // R10
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> ($stable(match_o) && $stable(st) && $stable(xs)));

  // R9
  flag_column_chk: assert property (@(posedge clk) disable iff (rst)
    match_o == col_any);

  // R9
  level_nest_chk: assert property (@(posedge clk) disable iff (rst)
    nest_ok);

  // R4
  exact_tail_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && st[0][M-1] && last_hit) |=> match_o);

endmodule

bind approx_match approx_match_chk #(.M(M), .K(K), .PAT_A(PAT_A), .PAT_B(PAT_B)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .in_valid (in_valid),
  .in_byte  (in_byte),
  .match_o  (match_o),
  .st       (grid_st),
  .xs       (xpose_st)
);

// File: tb/approx_match_tb.sv
module approx_match_tb;

  localparam int CLK_PERIOD = 10;
  localparam int BM = 5;
  localparam int BK = 1;
  localparam logic [8*BM-1:0] PA = "GRAPE";
  localparam logic [8*BM-1:0] PB = "GR4PE";

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       in_valid = 1'b0;
  logic [7:0] in_byte = 8'h00;
  logic       match_o;

  approx_match #(.M(BM), .K(BK), .PAT_A(PA), .PAT_B(PB)) u_dut (
    .clk      (clk),
    .rst      (rst),
    .in_valid (in_valid),
    .in_byte  (in_byte),
    .match_o  (match_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  typedef struct { bit exp; string tag; } item_t;
  item_t sb[$];
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // distance model: columns t-1 and t-2 of the free-start alignment table
  int  d1[0:BM];
  int  d2[0:BM];
  logic [7:0] prev_c;
  int  seen;
  bit  ref_exp;

  function automatic bit pos_eq(logic [7:0] c, int p);
    return (c == PA[8*(BM-p) +: 8]) || (c == PB[8*(BM-p) +: 8]);
  endfunction

  task automatic ref_reset();
    for (int i = 0; i <= BM; i++) begin d1[i] = i; d2[i] = i; end
    seen = 0;
    prev_c = 8'h00;
    ref_exp = 1'b0;
  endtask

  task automatic ref_step(logic [7:0] c);
    int nc[0:BM];
    nc[0] = 0;
    for (int i = 1; i <= BM; i++) begin
      int v;
      v = d1[i] + 1;
      if (nc[i-1] + 1 < v) v = nc[i-1] + 1;
      if (d1[i-1] + (pos_eq(c, i) ? 0 : 1) < v) v = d1[i-1] + (pos_eq(c, i) ? 0 : 1);
      if (seen >= 1 && i >= 2 && pos_eq(c, i-1) && pos_eq(prev_c, i) && d2[i-2] + 1 < v)
        v = d2[i-2] + 1;
      nc[i] = v;
    end
    for (int i = 0; i <= BM; i++) begin d2[i] = d1[i]; d1[i] = nc[i]; end
    prev_c = c;
    seen++;
    ref_exp = (d1[BM] <= BK);
  endtask

  task automatic drive(bit v, logic [7:0] c, bit r, bit exp, string tag);
    item_t it;
    @(negedge clk);
    rst = r;
    in_valid = v;
    in_byte = c;
    it.exp = exp;
    it.tag = tag;
    sb.push_back(it);
  endtask

  task automatic send(logic [7:0] c, string tag);
    ref_step(c);
    drive(1'b1, c, 1'b0, ref_exp, tag);
  endtask

  task automatic send_hand(logic [7:0] c, bit hand, string tag);
    ref_step(c);
    drive(1'b1, c, 1'b0, hand, tag);
  endtask

  task automatic idle(logic [7:0] c, bit hand, string tag);
    drive(1'b0, c, 1'b0, hand, tag);
  endtask

  task automatic do_reset(string tag);
    ref_reset();
    drive(1'b0, 8'h00, 1'b1, 1'b0, tag);
  endtask

  task automatic flush(string tag);
    for (int n = 0; n < 8; n++) send(".", tag);
  endtask

  task automatic run_str(string s, bit hand, string tag);
    flush(tag);
    for (int n = 0; n < s.len(); n++) begin
      if (n == s.len() - 1) send_hand(s[n], hand, tag);
      else                  send(s[n], tag);
    end
  endtask

  // monitor: one expectation per driven cycle, sampled after the edge
  always @(posedge clk) begin
    #1;
    if (sb.size() > 0) begin
      item_t it;
      it = sb.pop_front();
      checks++;
      if (match_o !== it.exp) begin
        errors++;
        $display("FAIL %s: match_o=%0b expected %0b", it.tag, match_o, it.exp);
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: match_o=%0b expected run to finish", match_o);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    string alpha;
    alpha = "GRAP4E.X";
    ref_reset();
    repeat (2) @(negedge clk);
    do_reset("R1");
    do_reset("R1");

    run_str("GRAPE", 1'b1, "R4");
    run_str("GR4PE", 1'b1, "R3");
    run_str("GRXPE", 1'b1, "R5");
    run_str("GRAXPE", 1'b1, "R6");
    run_str("GRPE", 1'b1, "R7");
    run_str("RAPE", 1'b1, "R7");
    run_str("GARPE", 1'b1, "R8");
    run_str("RGPAE", 1'b0, "R8");
    run_str("GXAXE", 1'b0, "R9");
    run_str("GRA", 1'b0, "R2");
    send_hand("P", 1'b1, "R2");

    // R10: idle bytes are ignored, flag holds
    run_str("GRAPE", 1'b1, "R10");
    idle(".", 1'b1, "R10");
    idle("E", 1'b1, "R10");
    idle(".", 1'b1, "R10");
    send_hand(".", 1'b1, "R10");
    send_hand(".", 1'b0, "R10");

    // R1: mid-stream reset drops history
    run_str("GRAPE", 1'b1, "R1");
    do_reset("R1");
    send_hand("E", 1'b0, "R1");

    for (int n = 0; n < 3000; n++) begin
      logic [7:0] c;
      c = alpha[$urandom_range(0, 7)];
      if ($urandom_range(0, 7) == 0) idle(c, ref_exp, "R10");
      else                           send(c, "R9");
    end

    idle(".", ref_exp, "R10");
    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule